// File: doc/BRIEF.md
# Serial EEPROM Register Initialization Sequencer

After reset this block can configure a chip before its processor runs. When the enable strap is set, it reads fixed-size records from a serial EEPROM through a simple byte-read request/response port. Each record is an address word followed by a data word. For each record it issues one write on an internal register bus. The sequence ends when a record's data word equals a configured terminator value. While the sequence runs, the processor is held in reset and an activity output is high. The serial bit engine is outside the block. It is modelled as a byte source that answers one read request at a time and reports a missing acknowledge as an error.

When the strap is clear, the block does nothing. It releases the processor reset at once, and configuration then depends only on the sampled pins. Two outcomes end an enabled run with an error flag and the reset released. One is a read error. The other is reaching the last EEPROM byte without finding a terminator.

Top module: `eeprom_init_seq`

## Requirements
- R1: With `initEnable` low in the first cycle after reset, the block issues no read and no write. `cpuResetN` rises within two cycles of reset release, and `initDone` and `initError` stay 0.
- R2: Reads start at EEPROM byte 0 and go up by one for each accepted byte. `rdDev` always carries the device bus address 0xA6. `rdReq` stays high until a response (`rdValid`) is accepted.
- R3: Bytes are assembled most significant first. Bytes 8k..8k+3 form the address word of record k, and bytes 8k+4..8k+7 form its data word.
- R4: Every record that is not a terminator produces exactly one write of its data word to its address. `wrValid`, `wrAddr` and `wrData` hold steady until `wrReady`. No read is requested while a write is pending.
- R5: A record ends the sequence only when its data word equals `TERM_WORD` exactly (default 0xFFFFFFFF). That record causes no write, and `initDone` is set. An address word equal to the terminator, or a data word that differs from it in one bit, does not end the sequence.
- R6: `cpuResetN` is 0 from reset until the sequence ends (terminator, error, or strap clear). After that it stays 1.
- R7: `initActive` is 1 exactly while an enabled sequence is reading, checking or writing. It is 0 at reset and after the sequence ends.
- R8: If the record that ends at the last EEPROM byte is not a terminator, its write is still issued. Then `initError` is set and the reset is released.
- R9: A read response with `rdErr` high aborts the run with no write for the partial record. `initError` is set and the reset is released.
- R10: Once the block reaches an end state (done, error or disabled), its outputs do not change until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| initEnable | input | 1 | Strap: run the EEPROM sequence after reset |
| rdReq | output | 1 | Byte read request, held until a response |
| rdDev | output | 8 | Serial device bus address of the EEPROM |
| rdAddr | output | EE_AW | EEPROM byte address being read |
| rdValid | input | 1 | Byte response valid |
| rdData | input | 8 | Byte read from the EEPROM |
| rdErr | input | 1 | Response carries a no-acknowledge error |
| wrValid | output | 1 | Register write request |
| wrAddr | output | AW | Register write address |
| wrData | output | DW | Register write data |
| wrReady | input | 1 | Register bus accepts the write |
| cpuResetN | output | 1 | Processor reset, low while held |
| initActive | output | 1 | Sequence in progress |
| initDone | output | 1 | Sequence enabled and completed on a terminator |
| initError | output | 1 | Sequence aborted by a read error or by the end of memory |

## Verification
A byte is taken at the edge where `rdValid` is high. After the eighth byte of a record, one cycle is spent on the terminator check. `wrValid` then rises in the cycle after that check. The next `rdReq` comes in the cycle after `wrReady` is accepted. Status outputs change one edge after the deciding response or handshake. The bench drives responses and ready at falling edges after random waits. It compares each write and each read address at the falling edge where it answers. It checks the end state and the final write count only after `cpuResetN` rises, and checks them again several cycles later for R10.

// File: rtl/eeinit_pkg.sv
package eeinit_pkg;

  typedef enum logic [2:0] {
    ST_BOOT  = 3'd0,
    ST_READ  = 3'd1,
    ST_CHECK = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4,
    ST_FAIL  = 3'd5,
    ST_OFF   = 3'd6
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shift;   // consume the byte on rdData
    logic wrOut;   // drive the assembled record onto the write bus
  } seqStrobe_t;

endpackage

// File: rtl/eeinit_dpath.sv
module eeinit_dpath
  import eeinit_pkg::*;
#(
  parameter int EE_BYTES  = 8192,
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter logic [DW-1:0] TERM_WORD = '1,
  localparam int EE_AW     = $clog2(EE_BYTES),
  localparam int REC_W     = AW + DW,
  localparam int REC_BYTES = REC_W / 8,
  localparam int RB_W      = $clog2(REC_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [7:0]       rdData,
  output logic [EE_AW-1:0] byteAddr,
  output logic [AW-1:0]    wrAddr,
  output logic [DW-1:0]    wrData,
  output logic             recLast,
  output logic             memEnd,
  output logic             isTerm
);

  logic [REC_W-1:0] recReg;
  logic [RB_W-1:0]  recByte;
  logic             lastByte;

  assign lastByte = (byteAddr == EE_AW'(EE_BYTES - 1));
  assign recLast  = (recByte == RB_W'(REC_BYTES - 1));
  assign isTerm   = (recReg[DW-1:0] == TERM_WORD);
  assign wrAddr   = strobe.wrOut ? recReg[REC_W-1 -: AW] : '0;
  assign wrData   = strobe.wrOut ? recReg[DW-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      recReg   <= '0;
      recByte  <= '0;
      byteAddr <= '0;
      memEnd   <= 1'b0;
    end else if (strobe.shift) begin
      recReg   <= {recReg[REC_W-9:0], rdData};
      recByte  <= recLast ? '0 : recByte + 1'b1;
      byteAddr <= lastByte ? '0 : byteAddr + 1'b1;
      if (lastByte) memEnd <= 1'b1;
    end
  end

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift && !lastByte |=> byteAddr == $past(byteAddr) + 1'b1);

  // R4
  rec_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrOut |=> $stable(recReg));

endmodule

// File: rtl/eeinit_ctrl.sv
module eeinit_ctrl
  import eeinit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       initEnable,
  input  logic       rdValid,
  input  logic       rdErr,
  input  logic       wrReady,
  input  logic       recLast,
  input  logic       memEnd,
  input  logic       isTerm,
  output seqStrobe_t strobe,
  output logic       rdReq,
  output logic       wrValid,
  output logic       cpuResetN,
  output logic       initActive,
  output logic       initDone,
  output logic       initError
);

  seqState_t state, nextState;

  always_comb begin
    nextState    = state;
    strobe.shift = 1'b0;
    strobe.wrOut = 1'b0;
    unique case (state)
      ST_BOOT:  nextState = initEnable ? ST_READ : ST_OFF;
      ST_READ: begin
        if (rdValid) begin
          if (rdErr) begin
            nextState = ST_FAIL;
          end else begin
            strobe.shift = 1'b1;
            if (recLast) nextState = ST_CHECK;
          end
        end
      end
      ST_CHECK: nextState = isTerm ? ST_DONE : ST_WRITE;
      ST_WRITE: begin
        strobe.wrOut = 1'b1;
        if (wrReady) nextState = memEnd ? ST_FAIL : ST_READ;
      end
      default: nextState = state;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_BOOT;
    else       state <= nextState;
  end

  assign rdReq      = (state == ST_READ);
  assign wrValid    = (state == ST_WRITE);
  assign initActive = (state == ST_READ) || (state == ST_CHECK) || (state == ST_WRITE);
  assign cpuResetN  = (state == ST_DONE) || (state == ST_FAIL) || (state == ST_OFF);
  assign initDone   = (state == ST_DONE);
  assign initError  = (state == ST_FAIL);

  // R6
  reset_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuResetN |=> cpuResetN);

  // R7
  active_holds_cpu_chk: assert property (@(posedge clk) disable iff (!rstN)
    initActive |-> !cpuResetN);

  // R9
  read_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && rdValid && rdErr |=> initError && !wrValid);

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (initDone || initError) |=> $stable({initDone, initError, cpuResetN}));

  // R4
  no_read_in_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !wrReady |=> wrValid && !rdReq);

endmodule

// File: rtl/eeprom_init_seq.sv
module eeprom_init_seq
  import eeinit_pkg::*;
#(
  parameter int EE_BYTES = 8192,
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter logic [7:0]    DEV_ADDR  = 8'hA6,
  parameter logic [DW-1:0] TERM_WORD = '1,
  localparam int EE_AW   = $clog2(EE_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             initEnable,
  output logic             rdReq,
  output logic [7:0]       rdDev,
  output logic [EE_AW-1:0] rdAddr,
  input  logic             rdValid,
  input  logic [7:0]       rdData,
  input  logic             rdErr,
  output logic             wrValid,
  output logic [AW-1:0]    wrAddr,
  output logic [DW-1:0]    wrData,
  input  logic             wrReady,
  output logic             cpuResetN,
  output logic             initActive,
  output logic             initDone,
  output logic             initError
);

  seqStrobe_t strobe;
  logic recLast, memEnd, isTerm;

  assign rdDev = DEV_ADDR;

  eeinit_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .initEnable(initEnable),
    .rdValid(rdValid), .rdErr(rdErr), .wrReady(wrReady),
    .recLast(recLast), .memEnd(memEnd), .isTerm(isTerm),
    .strobe(strobe), .rdReq(rdReq), .wrValid(wrValid),
    .cpuResetN(cpuResetN), .initActive(initActive),
    .initDone(initDone), .initError(initError)
  );

  eeinit_dpath #(
    .EE_BYTES(EE_BYTES), .AW(AW), .DW(DW), .TERM_WORD(TERM_WORD)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdData(rdData),
    .byteAddr(rdAddr), .wrAddr(wrAddr), .wrData(wrData),
    .recLast(recLast), .memEnd(memEnd), .isTerm(isTerm)
  );

  // R4
  wr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !wrReady |=> wrValid && $stable(wrAddr) && $stable(wrData));

  // R5
  done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(initDone && initError));

endmodule

// File: tb/tb_eeprom_init_seq.sv
module tb_eeprom_init_seq;
  localparam int EE_BYTES = 8192;
  localparam int RECS     = EE_BYTES / 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        initEnable = 1'b0;
  logic        rdReq;
  logic [7:0]  rdDev;
  logic [12:0] rdAddr;
  logic        rdValid = 1'b0;
  logic [7:0]  rdData = 8'h00;
  logic        rdErr = 1'b0;
  logic        wrValid;
  logic [31:0] wrAddr, wrData;
  logic        wrReady = 1'b0;
  logic        cpuResetN, initActive, initDone, initError;

  int nChecks = 0;
  int nFails  = 0;
  int termRec = 0, errAt = -1, maxLat = 0, salt = 0;
  int wrIdx = 0, rdSeen = 0, nextAddr = 0;

  always #5 clk = ~clk;

  eeprom_init_seq dut (
    .clk(clk), .rstN(rstN), .initEnable(initEnable),
    .rdReq(rdReq), .rdDev(rdDev), .rdAddr(rdAddr),
    .rdValid(rdValid), .rdData(rdData), .rdErr(rdErr),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .wrReady(wrReady),
    .cpuResetN(cpuResetN), .initActive(initActive),
    .initDone(initDone), .initError(initError)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mix(input int x);
    logic [31:0] v;
    v = 32'(x) * 32'h9E3779B1;
    v = v ^ (v >> 13) ^ 32'(salt);
    return v * 32'h85EBCA6B;
  endfunction

  function automatic logic [31:0] addrWord(input int rec);
    if (rec % 7 == 2) return 32'hFFFF_FFFF;
    return mix(2 * rec);
  endfunction

  function automatic logic [31:0] dataWord(input int rec);
    if (rec == termRec) return 32'hFFFF_FFFF;
    if (rec % 5 == 3)   return 32'hFFFF_FFFE;
    return mix(2 * rec + 1) & 32'h7FFF_FFFF;
  endfunction

  function automatic logic [7:0] memByte(input int a);
    logic [31:0] w;
    int idx;
    idx = a % 8;
    w = (idx < 4) ? addrWord(a / 8) : dataWord(a / 8);
    return w[8 * (3 - (idx % 4)) +: 8];
  endfunction

  function automatic int pickLat();
    if (maxLat == 0) return 0;
    return int'($urandom % (maxLat + 1));
  endfunction

  // byte source
  initial begin
    forever begin
      @(negedge clk);
      rdValid = 1'b0;
      rdErr   = 1'b0;
      if (rdReq && rstN) begin
        for (int w = pickLat(); w > 0; w--) begin
          @(negedge clk);
          chk(rdReq == 1'b1, "R2 request held", 64'(rdReq), 64'd1);
        end
        chk(int'(rdAddr) == nextAddr, "R2 read address", 64'(rdAddr), 64'(nextAddr));
        chk(rdDev == 8'hA6, "R2 device address", 64'(rdDev), 64'hA6);
        rdData  = memByte(int'(rdAddr));
        rdErr   = (int'(rdAddr) == errAt);
        rdValid = 1'b1;
        nextAddr++;
        rdSeen++;
      end
    end
  end

  // register bus sink
  initial begin
    forever begin
      @(negedge clk);
      wrReady = 1'b0;
      if (wrValid && rstN) begin
        chk(!cpuResetN && initActive, "R6 R7 held during write", {62'd0, cpuResetN, initActive}, 64'd1);
        for (int w = pickLat(); w > 0; w--) begin
          logic [31:0] a0, d0;
          a0 = wrAddr; d0 = wrData;
          @(negedge clk);
          chk(wrValid && !rdReq && wrAddr == a0 && wrData == d0, "R4 write held",
              {wrAddr, wrData}, {a0, d0});
        end
        chk(wrAddr == addrWord(wrIdx), "R3 write address", 64'(wrAddr), 64'(addrWord(wrIdx)));
        chk(wrData == dataWord(wrIdx), "R3 write data", 64'(wrData), 64'(dataWord(wrIdx)));
        wrReady = 1'b1;
        wrIdx++;
      end
    end
  end

  task automatic runScen(input bit en, input int tRec, input int eAt, input int lat, input string tag);
    int expWr, cyc;
    bit expDone, expErr;
    termRec = tRec; errAt = eAt; maxLat = lat; salt = int'($urandom);
    initEnable = en;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    wrIdx = 0; rdSeen = 0; nextAddr = 0;
    // R6 R7 reset state
    chk(!cpuResetN && !initActive && !initDone && !initError, "R6 R7 reset state",
        {60'd0, cpuResetN, initActive, initDone, initError}, 64'd0);
    rstN = 1'b1;
    if (!en) begin
      expWr = 0; expDone = 0; expErr = 0;
    end else if (eAt >= 0 && eAt < tRec * 8 + 8) begin
      expWr = eAt / 8; expDone = 0; expErr = 1;
    end else if (tRec < RECS) begin
      expWr = tRec; expDone = 1; expErr = 0;
    end else begin
      expWr = RECS; expDone = 0; expErr = 1;
    end
    cyc = 0;
    while (!cpuResetN && cyc < 60000) begin
      @(negedge clk);
      cyc++;
      if (!cpuResetN && cyc > 1)
        chk(initActive == en, {tag, " R7 active while running"}, 64'(initActive), 64'(en));
    end
    if (!en) begin
      chk(cyc <= 2 && rdSeen == 0, {tag, " R1 quick release no reads"}, 64'(cyc), 64'd1);
    end
    chk(wrIdx == expWr, {tag, " R4 R5 R8 R9 write count"}, 64'(wrIdx), 64'(expWr));
    chk(initDone == expDone && initError == expErr && cpuResetN && !initActive,
        {tag, " R5 R8 R9 R1 end status"},
        {60'd0, initDone, initError, cpuResetN, initActive}, {60'd0, expDone, expErr, 2'b10});
    repeat (6) @(negedge clk);
    chk(initDone == expDone && initError == expErr && cpuResetN && wrIdx == expWr && !rdReq,
        {tag, " R10 end state stable"}, {60'd0, initDone, initError, cpuResetN, rdReq},
        {60'd0, expDone, expErr, 2'b10});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5));
    runScen(1'b0, 4, -1, 2, "strap off");
    runScen(1'b1, 0, -1, 0, "terminator first");
    runScen(1'b1, 4, -1, 0, "short no wait");
    runScen(1'b1, 9, -1, 3, "near terminator values");
    for (int i = 0; i < 5; i++) begin
      int t, e;
      t = int'($urandom % 14) + 1;
      e = ($urandom % 2 == 1) ? int'($urandom % 120) : -1;
      runScen(1'b1, t, e, 3, "random");
    end
    runScen(1'b1, 6, 0, 1, "error first byte");
    runScen(1'b1, 10, 21, 2, "error mid record");
    runScen(1'b1, 10, 7, 2, "error last byte of record");
    runScen(1'b1, RECS, -1, 1, "no terminator");
    runScen(1'b1, RECS - 1, -1, 0, "terminator in last record");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule